// File: doc/BRIEF.md
# Microprogram Sequencer with Presettable Address Counter

This block runs microroutines out of a small fixed control store. A presettable counter supplies the store address. The microword at that address drives a wide bus of control lines into the rest of the processor in the same cycle. An external instruction code arrives on a data input. When it is accepted, the counter is preset to that exact value, so the code is itself the first address of its microroutine. No mapping table sits in between.

Once preset, the counter adds one every clock, so a routine occupies a contiguous run of addresses. Each microword carries a terminate flag. While the current word has that flag set, the block raises a fetch request. It then loads the next instruction on the first edge at which the instruction input is marked valid, and holds its address until that happens. Synchronous reset returns the counter to address 0. The word at address 0 is terminating, so fetching starts at once.

The store holds four routines:
- Routine 0: three words.
- Routine 1: four words.
- Routine 2: one word.
- Routine 3: two words, occupying the last two addresses of the space.

Every other address is a blank terminating word.

Top module: `useq_engine`

## Requirements
- R1: While `rst` is high at a rising edge, the counter goes to address 0. After release, `upc` is 0, `ctrl_out` is all zero and `fetch_req` is 1.
- R2: At a rising edge where `fetch_req` and `instr_valid` are both 1, `upc` takes the value of `instr_code`.
- R3: At a rising edge where `fetch_req` is 0, `upc` increases by exactly 1. `instr_valid` and `instr_code` have no effect in that cycle.
- R4: At a rising edge where `fetch_req` is 1 and `instr_valid` is 0, `upc` and `ctrl_out` keep their values and `fetch_req` stays 1.
- R5: `fetch_req` equals the terminate flag of the microword at the current `upc` in the same cycle, and `ctrl_out` is that word's control field. No register sits between the address and these outputs.
- R6: Routine lengths with the default bases are as follows:
  - Routine 0 starts at 16 and lasts 3 cycles.
  - Routine 1 starts at 32 and lasts 4 cycles.
  - Routine 2 starts at 48 and lasts 1 cycle.
  - Routine 3 starts at 1022 and lasts 2 cycles, ending on address 1023.

  Only the last word of each routine is terminating.
- R7: For a programmed word of routine k at step s (s counted from 0 at the routine base), `ctrl_out` has the following bits set and all others 0:
  - bits [9:0] equal to the address;
  - bit 10+4k+s set to 1;
  - bit 127 set to 1.
- R8: An instruction code that addresses no programmed word runs for exactly one cycle, with `ctrl_out` all zero and `fetch_req` at 1.
- R9: An instruction code that points into the middle of a routine runs from that word to the end of the routine.
- R10: An instruction accepted on a routine's terminating word starts its own routine on the next cycle, with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | The value on `instr_code` may be loaded |
| instr_code | input | 10 | External instruction, equal to its routine's start address |
| fetch_req | output | 1 | The current word terminates its routine; the next instruction is wanted |
| upc | output | 10 | Current control-store address |
| ctrl_out | output | 128 | Control field of the current microword |

## Verification
The bench uses the default parameters: a 10-bit address, 128 control lines, and routine bases 16, 32 and 48. With a 10-bit address, routine 3 lands on addresses 1022 and 1023, so the bench can show that the final address of the space runs and terminates correctly. The defaults also give routines of one to four words, so both single-word and multi-word routines are covered. Blank addresses such as 256, entry into the middle of routine 0, stalls with no valid instruction, and a reset in the middle of a routine are all reachable with these values.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Action taken by the address counter on the coming edge.
  typedef enum logic [1:0] {
    ACT_RESET = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_STEP  = 2'd2,
    ACT_WAIT  = 2'd3
  } useq_act_e;

  // Step lanes reserved per routine inside the control field.
  localparam int STEP_SLOTS = 4;
  localparam int ROUTINES   = 4;

  // Bit offset (above the address echo) of the marker for routine r, step s.
  function automatic int lane_of(input int routine, input int step);
    return routine * STEP_SLOTS + step;
  endfunction

  // Address arithmetic of the counter: advance by one, wrapping.
  function automatic logic [15:0] addr_next(input logic [15:0] a);
    return a + 16'd1;
  endfunction

endpackage

// File: rtl/useq_fetch_ctl.sv
module useq_fetch_ctl
  import useq_pkg::*;
(
  input  logic      rst,
  input  logic      end_flag,
  input  logic      instr_valid,
  output useq_act_e act,
  output logic      load_en,
  output logic      step_en,
  output logic      fetch_req
);

  always_comb begin
    if (rst)                      act = ACT_RESET;
    else if (!end_flag)           act = ACT_STEP;
    else if (instr_valid)         act = ACT_LOAD;
    else                          act = ACT_WAIT;
  end

  assign load_en   = (act == ACT_LOAD);
  assign step_en   = (act == ACT_STEP);
  assign fetch_req = end_flag && !rst;

endmodule

// File: rtl/useq_counter.sv
module useq_counter
  import useq_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic              step_en,
  input  logic [ADDR_W-1:0] din,
  output logic [ADDR_W-1:0] q
);

  logic [15:0] q_wide;
  logic [15:0] q_inc;

  assign q_wide = 16'(q);
  assign q_inc  = addr_next(q_wide);

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (load_en) q <= din;
    else if (step_en) q <= q_inc[ADDR_W-1:0];
  end

  // R2: a preset copies the data inputs into the counter.
  a_r2_preset_loads: assert property (@(posedge clk) disable iff (rst)
    (!rst && load_en) |=> (q == $past(din)));

  // R3: a step adds exactly one.
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (!rst && step_en && !load_en) |=> (q == $past(q) + 1'b1));

endmodule

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CTRL_W = 128,
  parameter int BASE_0 = 16,
  parameter int BASE_1 = 32,
  parameter int BASE_2 = 48,
  parameter int BASE_3 = (1 << ADDR_W) - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic              end_flag
);

  localparam logic [ADDR_W-1:0] R0S0 = ADDR_W'(BASE_0);
  localparam logic [ADDR_W-1:0] R0S1 = ADDR_W'(BASE_0 + 1);
  localparam logic [ADDR_W-1:0] R0S2 = ADDR_W'(BASE_0 + 2);
  localparam logic [ADDR_W-1:0] R1S0 = ADDR_W'(BASE_1);
  localparam logic [ADDR_W-1:0] R1S1 = ADDR_W'(BASE_1 + 1);
  localparam logic [ADDR_W-1:0] R1S2 = ADDR_W'(BASE_1 + 2);
  localparam logic [ADDR_W-1:0] R1S3 = ADDR_W'(BASE_1 + 3);
  localparam logic [ADDR_W-1:0] R2S0 = ADDR_W'(BASE_2);
  localparam logic [ADDR_W-1:0] R3S0 = ADDR_W'(BASE_3);
  localparam logic [ADDR_W-1:0] R3S1 = ADDR_W'(BASE_3 + 1);

  // Control field of a programmed word: address echo, one step marker,
  // and the top "programmed" line.
  function automatic logic [CTRL_W-1:0] word_of(input logic [ADDR_W-1:0] a,
                                                 input int routine,
                                                 input int step);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[ADDR_W-1:0] = a;
    w[ADDR_W + lane_of(routine, step)] = 1'b1;
    w[CTRL_W-1] = 1'b1;
    return w;
  endfunction

  always_comb begin
    ctrl_word = '0;
    end_flag  = 1'b1;
    case (addr)
      R0S0: begin ctrl_word = word_of(addr, 0, 0); end_flag = 1'b0; end
      R0S1: begin ctrl_word = word_of(addr, 0, 1); end_flag = 1'b0; end
      R0S2: begin ctrl_word = word_of(addr, 0, 2); end_flag = 1'b1; end
      R1S0: begin ctrl_word = word_of(addr, 1, 0); end_flag = 1'b0; end
      R1S1: begin ctrl_word = word_of(addr, 1, 1); end_flag = 1'b0; end
      R1S2: begin ctrl_word = word_of(addr, 1, 2); end_flag = 1'b0; end
      R1S3: begin ctrl_word = word_of(addr, 1, 3); end_flag = 1'b1; end
      R2S0: begin ctrl_word = word_of(addr, 2, 0); end_flag = 1'b1; end
      R3S0: begin ctrl_word = word_of(addr, 3, 0); end_flag = 1'b0; end
      R3S1: begin ctrl_word = word_of(addr, 3, 1); end_flag = 1'b1; end
      default: begin ctrl_word = '0; end_flag = 1'b1; end
    endcase
  end

endmodule

// File: rtl/useq_engine.sv
module useq_engine
  import useq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CTRL_W = 128,
  parameter int BASE_0 = 16,
  parameter int BASE_1 = 32,
  parameter int BASE_2 = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [ADDR_W-1:0] instr_code,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] upc,
  output logic [CTRL_W-1:0] ctrl_out
);

  localparam int BASE_3 = (1 << ADDR_W) - 2;

  // Named internal events, brought out for the assertions.
  logic      word_ends;
  logic      load_en;
  logic      step_en;
  useq_act_e act;

  useq_store #(
    .ADDR_W (ADDR_W),
    .CTRL_W (CTRL_W),
    .BASE_0 (BASE_0),
    .BASE_1 (BASE_1),
    .BASE_2 (BASE_2),
    .BASE_3 (BASE_3)
  ) u_store (
    .addr      (upc),
    .ctrl_word (ctrl_out),
    .end_flag  (word_ends)
  );

  useq_fetch_ctl u_ctl (
    .rst         (rst),
    .end_flag    (word_ends),
    .instr_valid (instr_valid),
    .act         (act),
    .load_en     (load_en),
    .step_en     (step_en),
    .fetch_req   (fetch_req)
  );

  useq_counter #(
    .ADDR_W (ADDR_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .step_en (step_en),
    .din     (instr_code),
    .q       (upc)
  );

  // R1: leaving reset finds the counter at address 0.
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (upc == '0));

  // R4: waiting for an instruction leaves the address untouched.
  a_r4_wait_holds: assert property (@(posedge clk) disable iff (rst)
    (!rst && fetch_req && !instr_valid) |=> $stable(upc));

  // R10: an accepted instruction is the very next address.
  a_r10_no_bubble: assert property (@(posedge clk) disable iff (rst)
    (!rst && fetch_req && instr_valid) |=> (upc == $past(instr_code)));

  // R3: a non-terminating word never loads, whatever the input.
  a_r3_input_ignored: assert property (@(posedge clk) disable iff (rst)
    (!rst && !fetch_req) |-> (act == ACT_STEP && !load_en));

endmodule

// File: tb/useq_engine_test.sv
`timescale 1ns/1ps
module useq_engine_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         instr_valid = 1'b0;
  logic [9:0]   instr_code = '0;
  logic         fetch_req;
  logic [9:0]   upc;
  logic [127:0] ctrl_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  useq_engine uut (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_code  (instr_code),
    .fetch_req   (fetch_req),
    .upc         (upc),
    .ctrl_out    (ctrl_out)
  );

  // Expected control field per R7 / R8.
  function automatic logic [127:0] exp_ctrl(input int a);
    logic [127:0] v;
    int k;
    int s;
    k = -1;
    s = 0;
    if (a >= 16 && a <= 18)       begin k = 0; s = a - 16;   end
    else if (a >= 32 && a <= 35)  begin k = 1; s = a - 32;   end
    else if (a == 48)             begin k = 2; s = 0;        end
    else if (a >= 1022)           begin k = 3; s = a - 1022; end
    v = '0;
    if (k >= 0) begin
      v[9:0] = a[9:0];
      v[10 + 4 * k + s] = 1'b1;
      v[127] = 1'b1;
    end
    return v;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Advance one edge; inputs are then changed 1 ns after it.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // Present an instruction while fetch_req is high; check the preset (R2).
  task automatic issue(input int code, input string req);
    instr_code  = 10'(code);
    instr_valid = 1'b1;
    cyc();
    chk(req, "preset upc", 128'(upc), 128'(code));
  endtask

  // Walk a routine of len words, pushing junk on the inputs meanwhile (R3).
  task automatic walk(input int code, input int len, input string req);
    for (int s = 0; s < len; s++) begin
      chk(req, "upc", 128'(upc), 128'(code + s));
      chk(req, "ctrl", ctrl_out, exp_ctrl(code + s));
      chk(req, "fetch_req", 128'(fetch_req), 128'(s == len - 1));
      if (s < len - 1) begin
        instr_code  = 10'h2AA;
        instr_valid = 1'b1;
        cyc();
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    instr_valid = 1'b0;
    cyc();
    cyc();
    rst = 1'b0;
    #0.5;
    chk("R1", "upc", 128'(upc), 128'd0);
    chk("R1", "ctrl", ctrl_out, 128'd0);
    chk("R1", "fetch_req", 128'(fetch_req), 128'd1);
  endtask

  task automatic t_wait_idle();
    instr_valid = 1'b0;
    instr_code  = 10'd32;
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk("R4", "idle upc", 128'(upc), 128'd0);
      chk("R4", "idle fetch_req", 128'(fetch_req), 128'd1);
    end
  endtask

  task automatic t_routines();
    issue(16, "R2");   walk(16, 3, "R6");
    issue(32, "R10");  walk(32, 4, "R6");
    issue(48, "R10");  walk(48, 1, "R6");
    issue(1022, "R7"); walk(1022, 2, "R6");
  endtask

  task automatic t_blank_and_mid();
    issue(256, "R8");  walk(256, 1, "R8");
    issue(0, "R8");    walk(0, 1, "R8");
    issue(17, "R9");   walk(17, 2, "R9");
  endtask

  task automatic t_stall_after_end();
    issue(32, "R2");
    walk(32, 4, "R3");
    instr_valid = 1'b0;
    for (int i = 0; i < 2; i++) begin
      cyc();
      chk("R4", "stall upc", 128'(upc), 128'd35);
      chk("R4", "stall ctrl", ctrl_out, exp_ctrl(35));
      chk("R4", "stall fetch_req", 128'(fetch_req), 128'd1);
    end
    issue(48, "R4");
    walk(48, 1, "R5");
  endtask

  task automatic t_reset_mid();
    issue(32, "R2");
    instr_valid = 1'b0;
    cyc();
    chk("R3", "mid upc", 128'(upc), 128'd33);
    rst = 1'b1;
    cyc();
    chk("R1", "reset mid upc", 128'(upc), 128'd0);
    rst = 1'b0;
    #0.5;
    chk("R1", "reset mid fetch_req", 128'(fetch_req), 128'd1);
    chk("R1", "reset mid ctrl", ctrl_out, 128'd0);
  endtask

  initial begin
    #1;
    t_reset();
    t_wait_idle();
    t_routines();
    t_blank_and_mid();
    t_stall_after_end();
    t_reset_mid();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule